// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies a run of items from a source address to a destination address over a single-beat bus-master port. Each item is first read into a one-item holding buffer and then written out. Three transfer types are supported: memory to memory, peripheral to memory and memory to peripheral. In the two peripheral types, each item is paced by a level request from the peripheral and is answered with a one-cycle acknowledge.

Software drives the channel through four 32-bit registers: control/status, source base, destination base and remaining count. The control register holds the following:
- enable;
- a self-clearing engine reset;
- the transfer type;
- a separate increment-or-fixed step for each address side;
- the item width used on the peripheral side;
- a sticky completion flag that software clears by writing 1 to it.

Working address pointers are loaded from the base registers when software turns the enable on. The count register decrements once per item. Register index 0 is control, 1 is source base, 2 is destination base and 3 is count.

Top module: `dma_chan`

## Requirements
- R1: Control bits [3:2] select the transfer type: 00 memory to memory, 01 peripheral to memory, 10 memory to peripheral. Code 11 behaves as memory to memory.
- R2: In the peripheral types, control bits [9:8] set the item width: 00 word, 01 byte, 10 half-word, 11 word. On the bus, m_size is 0 for a byte, 1 for a half-word and 2 for a word. Data sits right-aligned on the data lanes, and the unused upper lanes of a written item are zero.
- R3: In memory-to-memory transfers every item is a 32-bit word (m_size = 2), whatever the width field holds.
- R4: Control bits [5:4] (source) and [7:6] (destination) set address stepping independently. Code 00 advances the address by the item size in bytes after each item. Every other code keeps the address fixed.
- R5: A control write with bit 1 set returns the engine to idle, clears the working pointers and the holding buffer, clears enable (bit 0), and changes no other control field or the count. Bit 1 reads 1 during the two cycles after that write and then reads 0.
- R6: While enable is 0, m_req and per_ack stay low and the count is not changed, whatever per_req does.
- R7: In the peripheral types, no bus access for an item starts until per_req is high. per_ack is a single-cycle pulse in the cycle after the item's write completes.
- R8: Writing enable from 0 to 1 loads the working pointers from the base registers. A transfer runs while enable is 1 and the count is nonzero, and the count decrements by one per completed item.
- R9: The completion flag (control bit 16, also on done_o) sets when the count reaches zero. It stays set through control writes that carry bit 16 = 0 and clears on a control write with bit 16 = 1.
- R10: Each item is one read (m_we = 0) from the source pointer followed by one write (m_we = 1) to the destination pointer. m_req, m_addr and m_we are held until m_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 source, 2 destination, 3 count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | Bus access is a write |
| m_addr | output | 32 | Bus byte address |
| m_size | output | 2 | Access size: 0 byte, 1 half-word, 2 word |
| m_wdata | output | 32 | Bus write data, right-aligned |
| m_rdata | input | 32 | Bus read data, right-aligned |
| m_ready | input | 1 | Access completes in this cycle |
| per_req | input | 1 | Peripheral request level |
| per_ack | output | 1 | One-cycle acknowledge per peripheral item |
| done_o | output | 1 | Completion flag |

## Verification
The copy function is exercised with four traffic shapes:
- A word copy under a bus that stalls every other cycle, with the width field set to byte. This separates correct word transfers and request holding from width leakage.
- A byte-wide peripheral read from a fixed source whose value changes per item. This shows that increments follow item size and that each item waits for the request.
- A half-word peripheral write to a fixed target. This exposes lane masking and per-side stepping.
- A copy with a reserved destination step code, which must act as fixed.

Separate runs check the following:
- With enable low, a held request leaves the bus idle and the count unchanged.
- An engine reset during a stalled read drops the request, keeps the fields and reads back its self-clear timing.
- The completion flag survives writes without the clear bit and clears on a write with it.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int DATA_W = 32;

    // register indices
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SRC  = 2'd1;
    localparam logic [1:0] REG_DST  = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    // control bit positions
    localparam int B_EN   = 0;
    localparam int B_SRST = 1;
    localparam int B_MODE = 2;
    localparam int B_SSTP = 4;
    localparam int B_DSTP = 6;
    localparam int B_WID  = 8;
    localparam int B_DONE = 16;

    typedef enum logic [1:0] {
        XF_M2M = 2'b00,
        XF_P2M = 2'b01,
        XF_M2P = 2'b10,
        XF_RSV = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        IW_WORD = 2'b00,
        IW_BYTE = 2'b01,
        IW_HALF = 2'b10,
        IW_RSV  = 2'b11
    } item_wid_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_ACK
    } eng_state_e;

    typedef struct packed {
        logic       done;
        item_wid_e  wid;
        logic [1:0] dst_step;
        logic [1:0] src_step;
        xfer_mode_e mode;
        logic       en;
    } ctrl_t;

    function automatic logic is_periph(input xfer_mode_e m);
        return (m == XF_P2M) || (m == XF_M2P);
    endfunction

    // bus size code: 0 byte, 1 half, 2 word
    function automatic logic [1:0] bus_size(input xfer_mode_e m, input item_wid_e w);
        if (!is_periph(m))   return 2'd2;
        else if (w == IW_BYTE) return 2'd0;
        else if (w == IW_HALF) return 2'd1;
        else                 return 2'd2;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] mask_item(input logic [DATA_W-1:0] d,
                                                    input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(DATA_W-8){1'b0}},  d[7:0]};
            2'd1:    return {{(DATA_W-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic step_fixed(input logic [1:0] code);
        return code != 2'b00;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 16,
    parameter int SRST_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              item_done,
    output ctrl_t             ctrl_q,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    output logic [CW-1:0]     cnt_q,
    output logic              load_ptrs,
    output logic              eng_clr,
    output logic              rst_busy,
    output logic [31:0]       reg_rdata
);
    localparam int RCW = $clog2(SRST_CYC + 1);

    logic [RCW-1:0] rst_cnt;
    logic           wr_ctrl;
    logic           srst_wr;
    logic           last_item;

    assign wr_ctrl   = reg_we && (reg_addr == REG_CTRL);
    assign srst_wr   = wr_ctrl && reg_wdata[B_SRST];
    assign rst_busy  = (rst_cnt != '0);
    assign eng_clr   = srst_wr || rst_busy;
    assign last_item = item_done && (cnt_q == CW'(1));
    assign load_ptrs = wr_ctrl && reg_wdata[B_EN] && !reg_wdata[B_SRST]
                       && !ctrl_q.en && !rst_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            src_base <= '0;
            dst_base <= '0;
            cnt_q    <= '0;
            rst_cnt  <= '0;
        end else begin
            if (rst_busy)
                rst_cnt <= rst_cnt - RCW'(1);
            if (item_done && (cnt_q != '0))
                cnt_q <= cnt_q - CW'(1);
            if (last_item)
                ctrl_q.done <= 1'b1;
            if (reg_we) begin
                case (reg_addr)
                    REG_CTRL: begin
                        if (reg_wdata[B_SRST]) begin
                            rst_cnt   <= RCW'(SRST_CYC);
                            ctrl_q.en <= 1'b0;
                        end else begin
                            ctrl_q.en       <= reg_wdata[B_EN] && !rst_busy;
                            ctrl_q.mode     <= xfer_mode_e'(reg_wdata[B_MODE +: 2]);
                            ctrl_q.src_step <= reg_wdata[B_SSTP +: 2];
                            ctrl_q.dst_step <= reg_wdata[B_DSTP +: 2];
                            ctrl_q.wid      <= item_wid_e'(reg_wdata[B_WID +: 2]);
                            if (reg_wdata[B_DONE] && !last_item)
                                ctrl_q.done <= 1'b0;
                        end
                    end
                    REG_SRC: src_base <= reg_wdata[AW-1:0];
                    REG_DST: dst_base <= reg_wdata[AW-1:0];
                    default: cnt_q    <= reg_wdata[CW-1:0];
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[B_EN]        = ctrl_q.en;
                reg_rdata[B_SRST]      = rst_busy;
                reg_rdata[B_MODE +: 2] = ctrl_q.mode;
                reg_rdata[B_SSTP +: 2] = ctrl_q.src_step;
                reg_rdata[B_DSTP +: 2] = ctrl_q.dst_step;
                reg_rdata[B_WID +: 2]  = ctrl_q.wid;
                reg_rdata[B_DONE]      = ctrl_q.done;
            end
            REG_SRC: reg_rdata[AW-1:0] = src_base;
            REG_DST: reg_rdata[AW-1:0] = dst_base;
            default: reg_rdata[CW-1:0] = cnt_q;
        endcase
    end

endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          fixed,
    input  logic [2:0]    step,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (load)
            ptr <= base;
        else if (adv && !fixed)
            ptr <= ptr + AW'(step);
    end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  xfer_mode_e        mode,
    input  logic [1:0]        sz,
    input  logic              cnt_nz,
    input  logic              per_req,
    input  logic              m_ready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [AW-1:0]     src_ptr,
    input  logic [AW-1:0]     dst_ptr,
    output logic              m_req,
    output logic              m_we,
    output logic [AW-1:0]     m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [1:0]        m_size,
    output logic              per_ack,
    output logic              item_done
);
    eng_state_e        state, nxt;
    logic [DATA_W-1:0] hold_q;
    logic              active;
    logic              periph;

    assign active = en && !clr;
    assign periph = is_periph(mode);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (cnt_nz)  nxt = periph ? ST_WAIT : ST_READ;
            ST_WAIT:  if (per_req) nxt = ST_READ;
            ST_READ:  if (m_ready) nxt = ST_WRITE;
            ST_WRITE: if (m_ready) nxt = periph ? ST_ACK : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!active)
            nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hold_q <= '0;
        end else begin
            state <= nxt;
            if (clr)
                hold_q <= '0;
            else if (active && (state == ST_READ) && m_ready)
                hold_q <= mask_item(m_rdata, sz);
        end
    end

    assign m_req     = active && ((state == ST_READ) || (state == ST_WRITE));
    assign m_we      = m_req && (state == ST_WRITE);
    assign m_addr    = (state == ST_WRITE) ? dst_ptr : src_ptr;
    assign m_wdata   = hold_q;
    assign m_size    = sz;
    assign per_ack   = active && (state == ST_ACK);
    assign item_done = m_we && m_ready;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 16,
    parameter int SRST_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [1:0]  m_size,
    output logic [31:0] m_wdata,
    input  logic [31:0] m_rdata,
    input  logic        m_ready,
    input  logic        per_req,
    output logic        per_ack,
    output logic        done_o
);
    localparam int NSIDE = 2;

    ctrl_t          ctrl_q;
    logic [AW-1:0]  src_base, dst_base;
    logic [CW-1:0]  cnt_q;
    logic           load_ptrs, eng_clr, rst_busy, item_done;
    logic [1:0]     sz;
    logic [AW-1:0]  bases [NSIDE];
    logic [1:0]     codes [NSIDE];
    logic [AW-1:0]  ptrs  [NSIDE];
    logic [AW-1:0]  eng_addr;

    dma_regs #(.AW(AW), .CW(CW), .SRST_CYC(SRST_CYC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .item_done (item_done),
        .ctrl_q    (ctrl_q),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .cnt_q     (cnt_q),
        .load_ptrs (load_ptrs),
        .eng_clr   (eng_clr),
        .rst_busy  (rst_busy),
        .reg_rdata (reg_rdata)
    );

    assign sz       = bus_size(ctrl_q.mode, ctrl_q.wid);
    assign bases[0] = src_base;
    assign bases[1] = dst_base;
    assign codes[0] = ctrl_q.src_step;
    assign codes[1] = ctrl_q.dst_step;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_ptr #(.AW(AW)) u_ptr (
            .clk   (clk),
            .rst   (rst),
            .clr   (eng_clr),
            .load  (load_ptrs),
            .base  (bases[g]),
            .adv   (item_done),
            .fixed (step_fixed(codes[g])),
            .step  (size_bytes(sz)),
            .ptr   (ptrs[g])
        );
    end

    dma_engine #(.AW(AW)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .clr       (eng_clr),
        .en        (ctrl_q.en),
        .mode      (ctrl_q.mode),
        .sz        (sz),
        .cnt_nz    (cnt_q != '0),
        .per_req   (per_req),
        .m_ready   (m_ready),
        .m_rdata   (m_rdata),
        .src_ptr   (ptrs[0]),
        .dst_ptr   (ptrs[1]),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (eng_addr),
        .m_wdata   (m_wdata),
        .m_size    (m_size),
        .per_ack   (per_ack),
        .item_done (item_done)
    );

    assign m_addr = 32'(eng_addr);
    assign done_o = ctrl_q.done;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
    input logic        clk,
    input logic        rst,
    input logic        en_q,
    input logic        rst_busy,
    input logic [1:0]  mode_q,
    input logic        cnt_zero,
    input logic        m_req,
    input logic        m_ready,
    input logic        m_we,
    input logic [31:0] m_addr,
    input logic [1:0]  m_size,
    input logic        per_ack,
    input logic        done_o
);
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!m_req && !per_ack));

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);

    assert_ack_periph_only_R1: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> (mode_q == 2'b01 || mode_q == 2'b10));

    assert_word_in_m2m_R3: assert property (@(posedge clk) disable iff (rst)
        (m_req && (mode_q == 2'b00 || mode_q == 2'b11)) |-> (m_size == 2'd2));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ready) |=> (!m_req || ($stable(m_addr) && $stable(m_we))));

    assert_srst_drops_en_R5: assert property (@(posedge clk) disable iff (rst)
        rst_busy |-> !en_q);

    assert_srst_two_cycles_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_busy) |=> rst_busy);

    assert_done_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> cnt_zero);
endmodule

bind dma_chan dma_chan_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_q     (ctrl_q.en),
    .rst_busy (rst_busy),
    .mode_q   (ctrl_q.mode),
    .cnt_zero (cnt_q == '0),
    .m_req    (m_req),
    .m_ready  (m_ready),
    .m_we     (m_we),
    .m_addr   (m_addr),
    .m_size   (m_size),
    .per_ack  (per_ack),
    .done_o   (done_o)
);

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
module sim_dma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        m_req, m_we, m_ready, per_ack, done_o;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;
    logic        per_req = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // bus model controls
    logic        stall_en = 1'b0;
    logic        hold_rdy = 1'b0;
    logic        tgl = 1'b0;
    logic        pk_en = 1'b0;
    logic [5:0]  pk_i = '0;
    logic [31:0] pk_v = '0;
    logic [31:0] mem [64];
    logic [31:0] wl_a [64];
    logic [31:0] wl_d [64];
    logic [1:0]  wl_s [64];
    int          wn = 0;
    int          req_seen = 0;
    int          ack_seen = 0;

    always #2.5 clk = ~clk;

    dma_chan u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req),
        .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .per_req(per_req),
        .per_ack(per_ack), .done_o(done_o)
    );

    assign m_ready = hold_rdy ? 1'b0 : (stall_en ? tgl : 1'b1);
    assign m_rdata = mem[m_addr[7:2]] >> {m_addr[1:0], 3'b000};

    always @(posedge clk) begin
        tgl <= ~tgl;
        if (m_req) req_seen <= req_seen + 1;
        if (per_ack) ack_seen <= ack_seen + 1;
        if (pk_en) mem[pk_i] <= pk_v;
        if (m_req && m_we && m_ready) begin
            case (m_size)
                2'd0:    mem[m_addr[7:2]][{m_addr[1:0], 3'b000} +: 8]  <= m_wdata[7:0];
                2'd1:    mem[m_addr[7:2]][{m_addr[1], 4'b0000} +: 16] <= m_wdata[15:0];
                default: mem[m_addr[7:2]] <= m_wdata;
            endcase
            wl_a[wn % 64] <= m_addr;
            wl_d[wn % 64] <= m_wdata;
            wl_s[wn % 64] <= m_size;
            wn <= wn + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic poke(input int i, input logic [31:0] v);
        @(negedge clk);
        pk_en = 1'b1; pk_i = 6'(i); pk_v = v;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done_o && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(req, "completion flag", 32'(done_o), 32'd1);
    endtask

    task automatic serve_one();
        per_req = 1'b1;
        do @(negedge clk); while (!per_ack);
        per_req = 1'b0;
        @(negedge clk);
    endtask

    // disable, clear flag, program bases and count, then enable
    task automatic launch(input logic [31:0] cbits, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
        wr(2'd0, 32'h0001_0000);
        wr(2'd1, s);
        wr(2'd2, d);
        wr(2'd3, n);
        wr(2'd0, cbits | 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R5", "control after reset", v, 32'h0);
        rd(2'd3, v); chk("R8", "count after reset", v, 32'h0);
        chk("R6", "m_req after reset", 32'(m_req), 32'd0);
        chk("R7", "per_ack after reset", 32'(per_ack), 32'd0);
        chk("R9", "done after reset", 32'(done_o), 32'd0);
    endtask

    // word copy, stalling bus, width field = byte (must be ignored)
    task automatic t_m2m();
        logic [31:0] v;
        int w0;
        for (int i = 0; i < 4; i++) poke(i, 32'h0123_4567 + 32'(i) * 32'h1111_1111);
        for (int i = 0; i < 4; i++) poke(32 + i, 32'h0);
        stall_en = 1'b1;
        w0 = wn;
        launch(32'h0000_0100, 32'd0, 32'd128, 32'd4);
        wait_done("R9");
        stall_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk("R3", "m2m copied word", mem[32 + i], 32'h0123_4567 + 32'(i) * 32'h1111_1111);
        for (int i = 0; i < 4; i++) begin
            chk("R3", "m2m write size", 32'(wl_s[(w0 + i) % 64]), 32'd2);
            chk("R4", "m2m dst increments by 4", wl_a[(w0 + i) % 64], 32'd128 + 32'(4 * i));
        end
        rd(2'd3, v); chk("R8", "count reaches zero", v, 32'h0);
    endtask

    task automatic t_done_w1c();
        logic [31:0] v;
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R9", "flag kept on write without clear bit", v[16], 1'b1);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, v); chk("R9", "flag cleared by write-1", v[16], 1'b0);
        chk("R9", "done_o cleared", 32'(done_o), 32'd0);
    endtask

    // peripheral -> memory, bytes, fixed source, incrementing dest
    task automatic t_p2m_byte();
        int w0, r0, a0;
        poke(32, 32'h0);
        w0 = wn;
        launch(32'h0000_0124, 32'd8, 32'd128, 32'd4);
        r0 = req_seen;
        repeat (20) @(negedge clk);
        chk("R7", "no bus access before request", 32'(req_seen - r0), 32'd0);
        a0 = ack_seen;
        for (int k = 0; k < 4; k++) begin
            poke(2, 32'hFFFF_FF00 | 32'(8'hA0 + k));
            serve_one();
        end
        wait_done("R9");
        chk("R7", "one ack per item", 32'(ack_seen - a0), 32'd4);
        chk("R2", "bytes packed at dest", mem[32], 32'hA3A2_A1A0);
        for (int k = 0; k < 4; k++) begin
            chk("R2", "byte write size", 32'(wl_s[(w0 + k) % 64]), 32'd0);
            chk("R2", "byte data masked", wl_d[(w0 + k) % 64], 32'(8'hA0 + k));
            chk("R4", "dest steps by 1", wl_a[(w0 + k) % 64], 32'd128 + 32'(k));
        end
    endtask

    // memory -> peripheral, half-words, incrementing source, fixed dest
    task automatic t_m2p_half();
        int w0;
        poke(0, 32'hBEEF_CAFE);
        poke(1, 32'h1234_5678);
        w0 = wn;
        launch(32'h0000_0288, 32'd0, 32'd200, 32'd3);
        for (int k = 0; k < 3; k++) serve_one();
        wait_done("R9");
        chk("R2", "half 0 data", wl_d[w0 % 64], 32'h0000_CAFE);
        chk("R2", "half 1 data", wl_d[(w0 + 1) % 64], 32'h0000_BEEF);
        chk("R2", "half 2 data", wl_d[(w0 + 2) % 64], 32'h0000_5678);
        for (int k = 0; k < 3; k++) begin
            chk("R4", "fixed dest address", wl_a[(w0 + k) % 64], 32'd200);
            chk("R2", "half write size", 32'(wl_s[(w0 + k) % 64]), 32'd1);
        end
    endtask

    // reserved destination step code must act as fixed
    task automatic t_rsv_step();
        int w0;
        poke(4, 32'h5555_0001);
        poke(5, 32'h6666_0002);
        w0 = wn;
        launch(32'h0000_0040, 32'd16, 32'd240, 32'd2);
        wait_done("R9");
        @(negedge clk);
        chk("R4", "reserved step first addr", wl_a[w0 % 64], 32'd240);
        chk("R4", "reserved step second addr", wl_a[(w0 + 1) % 64], 32'd240);
        chk("R10", "last word lands at fixed dest", mem[60], 32'h6666_0002);
    endtask

    task automatic t_enable_off();
        logic [31:0] v;
        int r0, a0;
        wr(2'd0, 32'h0001_0004);
        wr(2'd3, 32'd3);
        r0 = req_seen; a0 = ack_seen;
        per_req = 1'b1;
        repeat (20) @(negedge clk);
        per_req = 1'b0;
        chk("R6", "no bus access while off", 32'(req_seen - r0), 32'd0);
        chk("R6", "no ack while off", 32'(ack_seen - a0), 32'd0);
        rd(2'd3, v); chk("R6", "count untouched while off", v, 32'd3);
    endtask

    task automatic t_swreset();
        logic [31:0] v;
        int w0;
        hold_rdy = 1'b1;
        launch(32'h0000_0024, 32'd8, 32'd128, 32'd5);
        per_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10", "read held while bus stalls", 32'(m_req), 32'd1);
        chk("R10", "held access is a read", 32'(m_we), 32'd0);
        wr(2'd0, 32'h0000_0002);
        rd(2'd0, v); chk("R5", "reset bit set, fields kept, enable off", v, 32'h0000_0026);
        chk("R5", "request dropped by reset", 32'(m_req), 32'd0);
        @(negedge clk);
        rd(2'd0, v); chk("R5", "reset bit still set second cycle", v[1], 1'b1);
        @(negedge clk);
        rd(2'd0, v); chk("R5", "reset bit self-cleared", v, 32'h0000_0024);
        rd(2'd3, v); chk("R5", "count kept", v, 32'd5);
        per_req = 1'b0;
        hold_rdy = 1'b0;
        poke(2, 32'h0000_0077);
        w0 = wn;
        wr(2'd0, 32'h0000_0025);
        for (int k = 0; k < 5; k++) serve_one();
        wait_done("R8");
        chk("R8", "pointer reloaded after re-enable", wl_a[w0 % 64], 32'd128);
        chk("R8", "fifth item address", wl_a[(w0 + 4) % 64], 32'd144);
    endtask

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog (all) actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_m2m();
        t_done_w1c();
        t_p2m_byte();
        t_m2p_half();
        t_rsv_step();
        t_enable_off();
        t_swreset();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule